// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a direct-mapped table that is read with the address of the instruction being fetched. It answers two questions before the instruction is decoded. Is this address a branch already recorded in the table? If it is, and the entry's direction counter leans taken, where should fetch go next? On a hit with a taken prediction, the stored target comes back on the same cycle as the fetch address. In every other case the next fetch address is the fetch address plus four.

Later pipeline stages report each branch they have worked out on a resolve port. Each report carries the branch address, the real direction and the real target. The block compares the report with what the table held and updates the table in the same clock. A taken branch that missed is inserted. A branch that hits moves its 2-bit counter one step toward its real direction, and a taken hit has its target rewritten. One cycle after the report, the block gives the front end a penalty code: 0, 1 or 2 cycles.

Resolve reports are single-cycle strobes and are never back-pressured. The table accepts one report in every clock. The fetch lookup is purely combinational and also needs no handshake.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset, no fetch address hits until a taken branch has been inserted.
- R2: On a miss, fetch_hit and fetch_taken are 0 and fetch_next_pc equals fetch_pc + 4.
- R3: On a hit whose counter is 2'b10 or 2'b11 (counter bit 1 set), fetch_taken is 1 and fetch_next_pc is the stored target, in the same cycle as fetch_pc.
- R4: On a hit whose counter is 2'b00 or 2'b01, fetch_hit is 1, fetch_taken is 0 and fetch_next_pc is fetch_pc + 4.
- R5: A resolved taken branch that misses gives penalty code 1. It is inserted with its target and the counter 2'b10 (weakly taken).
- R6: A resolved branch that hits, where the predicted direction and (if taken) the stored target are both right, gives penalty code 0.
- R7: A resolved branch that hits with the wrong direction, or taken with a different target, gives penalty code 2. The entry is corrected: a taken outcome stores the new target.
- R8: A not-taken outcome on a hit moves the counter down by one, saturating at 2'b00. The entry stays valid.
- R9: A taken outcome on a hit moves the counter up by one, saturating at 2'b11.
- R10: A not-taken branch that misses gives penalty code 0, and the table is left unchanged.
- R11: pen_valid is 1 exactly in the cycle after each res_valid cycle. pen_cycles is 0, 1 or 2 and never 3.
- R12: The index is pc[IDX_W+1:2] and the tag is pc[PC_W-1:IDX_W+2]. An address with the same index but a different tag misses. Inserting it replaces the older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_hit | output | 1 | Address matches a valid entry |
| fetch_taken | output | 1 | Hit with counter predicting taken |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | Resolve report strobe |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the branch |
| res_target | input | PC_W | Real target of the branch |
| pen_valid | output | 1 | Penalty code valid, one cycle after res_valid |
| pen_cycles | output | 2 | Penalty cycles: 0, 1 or 2 |

## Verification
One branch address is driven through every counter state with runs of taken and not-taken outcomes. These runs separate a saturating counter from one that wraps, and a two-miss hysteresis from a one-bit flip. A taken report with a changed target separates a direction check from a full target check. A not-taken report at an empty index separates "miss costs nothing when not taken" from an insert that fires on every report. An aliasing address at the same index tells a real tag compare apart from index-only matching, and the older branch must then miss.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  typedef enum logic [1:0] {
    PEN_NONE    = 2'd0,
    PEN_MISS    = 2'd1,
    PEN_MISPRED = 2'd2
  } pen_e;

  localparam logic [1:0] CTR_INIT = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] ctr, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (ctr == 2'b11) ? ctr : ctr + 2'd1;
    else    nxt = (ctr == 2'b00) ? ctr : ctr - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/fbt_table.sv
module fbt_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W   = PC_W - IDX_W - 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PC_W-1:0]  a_target,
  output logic [1:0]       a_ctr,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output logic [PC_W-1:0]  b_target,
  output logic [1:0]       b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target,
  input  logic [1:0]       wr_ctr
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [PC_W-1:0]    target_q [ENTRIES];
  logic [1:0]         ctr_q    [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    wire sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e]    <= wr_tag;
        target_q[e] <= wr_target;
        ctr_q[e]    <= wr_ctr;
      end
    end
  end

  assign a_valid  = valid_q[a_idx];
  assign a_tag    = tag_q[a_idx];
  assign a_target = target_q[a_idx];
  assign a_ctr    = ctr_q[a_idx];
  assign b_valid  = valid_q[b_idx];
  assign b_tag    = tag_q[b_idx];
  assign b_target = target_q[b_idx];
  assign b_ctr    = ctr_q[b_idx];

endmodule

// File: rtl/fbt_resolve.sv
module fbt_resolve
  import fbt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_target,
  input  logic [1:0]       rd_ctr,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_target,
  output logic [1:0]       wr_ctr,
  output pen_e             penalty
);

  logic was_hit, guessed_taken, guess_ok;

  always_comb begin
    was_hit       = rd_valid && (rd_tag == res_tag);
    guessed_taken = rd_ctr[1];
    guess_ok      = (guessed_taken == res_taken) &&
                    (!res_taken || (rd_target == res_target));
    wr_tag        = res_tag;
    if (was_hit) begin
      wr_en     = res_valid;
      wr_ctr    = ctr_step(rd_ctr, res_taken);
      wr_target = res_taken ? res_target : rd_target;
      penalty   = guess_ok ? PEN_NONE : PEN_MISPRED;
    end else begin
      wr_en     = res_valid && res_taken;
      wr_ctr    = CTR_INIT;
      wr_target = res_target;
      penalty   = res_taken ? PEN_MISS : PEN_NONE;
    end
  end

endmodule

// File: rtl/fbt_lookup.sv
module fbt_lookup #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_target,
  input  logic [1:0]       rd_ctr,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_comb begin
    hit     = rd_valid && (rd_tag == pc[PC_W-1:IDX_W+2]);
    taken   = hit && rd_ctr[1];
    next_pc = taken ? rd_target : pc + STEP;
  end

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import fbt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic            fetch_taken,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            pen_valid,
  output logic [1:0]      pen_cycles
);

  localparam int TAG_W = PC_W - IDX_W - 2;

  logic             a_valid, b_valid, wr_en;
  logic [TAG_W-1:0] a_tag, b_tag, wr_tag;
  logic [PC_W-1:0]  a_target, b_target, wr_target;
  logic [1:0]       a_ctr, b_ctr, wr_ctr;
  pen_e             penalty;
  logic             unused_res_lsb;

  assign unused_res_lsb = ^res_pc[1:0];

  fbt_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk, .rst_n,
    .a_idx(fetch_pc[IDX_W+1:2]), .a_valid, .a_tag, .a_target, .a_ctr,
    .b_idx(res_pc[IDX_W+1:2]),   .b_valid, .b_tag, .b_target, .b_ctr,
    .wr_en, .wr_idx(res_pc[IDX_W+1:2]), .wr_tag, .wr_target, .wr_ctr
  );

  fbt_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
    .pc(fetch_pc), .rd_valid(a_valid), .rd_tag(a_tag), .rd_target(a_target),
    .rd_ctr(a_ctr), .hit(fetch_hit), .taken(fetch_taken), .next_pc(fetch_next_pc)
  );

  fbt_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
    .res_valid, .res_tag(res_pc[PC_W-1:IDX_W+2]), .res_taken, .res_target,
    .rd_valid(b_valid), .rd_tag(b_tag), .rd_target(b_target), .rd_ctr(b_ctr),
    .wr_en, .wr_tag, .wr_target, .wr_ctr, .penalty
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_valid  <= 1'b0;
      pen_cycles <= 2'd0;
    end else begin
      pen_valid  <= res_valid;
      pen_cycles <= res_valid ? penalty : 2'd0;
    end
  end

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_hit,
  input logic            fetch_taken,
  input logic [PC_W-1:0] fetch_next_pc,
  input logic            res_valid,
  input logic            pen_valid,
  input logic [1:0]      pen_cycles
);

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fetch_hit);

  a_r2_miss_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> (fetch_next_pc == fetch_pc + PC_W'(4)) && !fetch_taken);

  a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_taken |-> fetch_hit);

  a_r4_not_taken_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && !fetch_taken) |-> (fetch_next_pc == fetch_pc + PC_W'(4)));

  a_r11_pen_follows_report: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> pen_valid);

  a_r11_no_spurious_pen: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> !pen_valid);

  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    pen_valid |-> (pen_cycles != 2'd3));

endmodule

bind fetch_target_buffer fbt_checker #(.PC_W(PC_W)) u_fbt_checker (
  .clk, .rst_n, .fetch_pc, .fetch_hit, .fetch_taken, .fetch_next_pc,
  .res_valid, .pen_valid, .pen_cycles
);

// File: tb/fetch_target_buffer_tb.sv
module fetch_target_buffer_tb;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            fetch_hit, fetch_taken;
  logic [PC_W-1:0] fetch_next_pc;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic            pen_valid;
  logic [1:0]      pen_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  fetch_target_buffer #(.PC_W(PC_W), .IDX_W(4)) u_dut (
    .clk, .rst_n, .fetch_pc, .fetch_hit, .fetch_taken, .fetch_next_pc,
    .res_valid, .res_pc, .res_taken, .res_target, .pen_valid, .pen_cycles
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, input bit e_hit, input bit e_tk,
                        input logic [PC_W-1:0] e_next, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(fetch_hit == e_hit && fetch_taken == e_tk && fetch_next_pc == e_next, req,
          $sformatf("pc=%h got hit=%0d tk=%0d next=%h, exp hit=%0d tk=%0d next=%h",
                    pc, fetch_hit, fetch_taken, fetch_next_pc, e_hit, e_tk, e_next));
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input bit tk,
                         input logic [PC_W-1:0] tgt, input int e_pen, input string req);
    @(negedge clk);
    res_valid  = 1'b1;
    res_pc     = pc;
    res_taken  = tk;
    res_target = tgt;
    exp_q.push_back(e_pen);
    tag_q.push_back(req);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (pen_valid && exp_q.size() == 0) begin
        check(0, "R11", "pen_valid with no report pending, got 1 exp 0");
      end else if (exp_q.size() > 0) begin
        automatic int    e = exp_q.pop_front();
        automatic string r = tag_q.pop_front();
        check(pen_valid == 1'b1, "R11", $sformatf("pen_valid got %0d exp 1", pen_valid));
        check(int'(pen_cycles) == e, r, $sformatf("penalty got %0d exp %0d", pen_cycles, e));
      end
    end
  end

  localparam logic [PC_W-1:0] A  = 32'h0000_0100;
  localparam logic [PC_W-1:0] B  = 32'h0000_0204;
  localparam logic [PC_W-1:0] C  = 32'h0000_0140;
  localparam logic [PC_W-1:0] T1 = 32'h0000_0400;
  localparam logic [PC_W-1:0] T2 = 32'h0000_0800;
  localparam logic [PC_W-1:0] T3 = 32'h0000_0900;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lookup(A, 0, 0, A + 4, "R1");
    lookup(B, 0, 0, B + 4, "R2");
    resolve(A, 1, T1, 1, "R5");
    lookup(A, 1, 1, T1, "R3");
    resolve(A, 1, T1, 0, "R6");
    resolve(A, 0, T1, 2, "R7");
    lookup(A, 1, 1, T1, "R8");
    resolve(A, 0, T1, 2, "R7");
    lookup(A, 1, 0, A + 4, "R4");
    resolve(A, 0, T1, 0, "R6");
    resolve(A, 0, T1, 0, "R8");
    resolve(A, 1, T1, 2, "R8");
    lookup(A, 1, 0, A + 4, "R8");
    resolve(A, 1, T1, 2, "R9");
    lookup(A, 1, 1, T1, "R9");
    for (int i = 0; i < 3; i++) resolve(A, 1, T1, 0, "R9");
    resolve(A, 0, T1, 2, "R9");
    lookup(A, 1, 1, T1, "R9");
    resolve(A, 1, T2, 2, "R7");
    lookup(A, 1, 1, T2, "R7");
    resolve(B, 0, T3, 0, "R10");
    lookup(B, 0, 0, B + 4, "R10");
    lookup(C, 0, 0, C + 4, "R12");
    resolve(C, 1, T3, 1, "R12");
    lookup(C, 1, 1, T3, "R12");
    lookup(A, 0, 0, A + 4, "R12");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11",
          $sformatf("pending penalties got %0d exp 0", exp_q.size()));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule